// File: doc/BRIEF.md
# Flag-Masked Relative Branch Next-PC Unit

This block computes the next program counter for a machine with fixed 16-bit instructions and byte addressing. Each cycle it takes the current PC, the instruction word and the carry, zero and negative condition flags. It registers the next PC and a taken indication. Only one opcode is a branch. Every other opcode moves to the next sequential instruction.

The branch condition is a masked OR. Three select bits in the instruction choose any subset of the carry, zero and negative flags. The branch is taken when any chosen flag is set. For example, selecting carry and zero together gives an unsigned lower-or-same test after a compare. The offset is a signed count of 16-bit words, measured from the instruction that follows the branch. All address arithmetic wraps at 16 bits.

The results are registered, so they appear one clock after the inputs. A generate option chooses the target datapath. One variant uses two adders: a sequential adder feeding a target adder, with a final multiplexer. The other variant uses one adder whose addend is gated by the condition.

Top module: `brnch_next_pc`

## Requirements
- R1: While `rst_n` is low, `next_pc` reads 0 and `br_taken` reads 0.
- R2: Both outputs are registered. The values sampled at one rising clock edge appear after that edge and hold until the next edge.
- R3: The opcode sits in instruction bits 15..11, and the value 00000 marks the branch. Any other opcode gives `next_pc` = PC+2 with `br_taken` low, whatever the select bits, offset and flags are.
- R4: Select bit 10 enables the carry flag, bit 9 enables the zero flag and bit 8 enables the negative flag. A branch is taken exactly when at least one enabled flag is 1. A flag whose select bit is 0 has no effect.
- R5: A branch whose three select bits are all 0 is never taken, for any flag values.
- R6: A taken branch gives `next_pc` = PC + 2 + 2×offset. The offset is bits 7..0, read as two's complement and sign-extended.
- R7: A branch that is not taken gives `next_pc` = PC+2.
- R8: All address sums are taken modulo 2^16. This applies at the top of memory and for backward offsets below address 0.
- R9: Take PC 200Ch with select bits 011 and offset E3h. With only the negative flag set, the result is 1FD4h and taken. With only the carry flag set, the result is 200Eh and not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cur_pc | input | 16 | Address of the instruction being resolved |
| insn | input | 16 | Instruction word |
| flag_c | input | 1 | Carry condition flag |
| flag_z | input | 1 | Zero condition flag |
| flag_n | input | 1 | Negative condition flag |
| next_pc | output | 16 | Registered next program counter |
| br_taken | output | 1 | Registered branch-taken indication |

## Verification
The block holds no state beyond its output registers. Any fault in the decode, the condition or the adders therefore shows up at the ports one clock after the triggering vector, either as a wrong `next_pc` or as a wrong `br_taken`. A fault in the flag-to-select-bit pairing shows only when a single flag and a single select bit are active, so every pairing is applied one at a time. Faults in sign extension or wrapping show only at offsets of 80h and above and at PCs near 0 or FFFEh, so those corners are driven directly. Pseudo-random vectors then cover the remaining mixes.

// File: rtl/brnch_pkg.sv
package brnch_pkg;
   localparam int FLAG_CNT = 3;
   // Flag index inside the select / flag vectors; order follows insn bits 10..8
   typedef enum logic [1:0] {
      FI_N = 2'd0,
      FI_Z = 2'd1,
      FI_C = 2'd2
   } flag_idx_e;
endpackage

// File: rtl/brnch_decode.sv
module brnch_decode #(
   parameter int OPC_W  = 5,
   parameter int OFS_W  = 8,
   parameter int INSN_W = 16,
   parameter logic [OPC_W-1:0] BR_OPC = '0
) (
   input  logic [INSN_W-1:0]              insn,
   output logic                           is_br,
   output logic [brnch_pkg::FLAG_CNT-1:0] sel,
   output logic [OFS_W-1:0]               ofs
);
   localparam int OPC_LSB = INSN_W - OPC_W;
   localparam int SEL_LSB = OFS_W;

   always_comb begin
      is_br = (insn[INSN_W-1:OPC_LSB] == BR_OPC);
      sel   = insn[SEL_LSB +: brnch_pkg::FLAG_CNT];
      ofs   = insn[OFS_W-1:0];
   end
endmodule

// File: rtl/brnch_cond.sv
module brnch_cond #(
   parameter int NF = brnch_pkg::FLAG_CNT
) (
   input  logic          is_br,
   input  logic [NF-1:0] sel,
   input  logic [NF-1:0] flags,
   output logic          take
);
   logic [NF-1:0] hit;

   for (genvar gi = 0; gi < NF; gi++) begin : g_hit
      assign hit[gi] = sel[gi] & flags[gi];
   end

   assign take = is_br & (|hit);
endmodule

// File: rtl/brnch_target.sv
module brnch_target #(
   parameter int PC_W       = 16,
   parameter int OFS_W      = 8,
   parameter bit DUAL_ADDER = 1'b1
) (
   input  logic [PC_W-1:0]  pc,
   input  logic [OFS_W-1:0] ofs,
   input  logic             take,
   output logic [PC_W-1:0]  npc
);
   localparam int EXT_W = PC_W - OFS_W - 1;
   localparam logic [PC_W-1:0] STEP = PC_W'(2);

   logic [PC_W-1:0] disp;
   assign disp = {{EXT_W{ofs[OFS_W-1]}}, ofs, 1'b0};

   if (DUAL_ADDER) begin : g_dual
      logic [PC_W-1:0] seq_pc;
      logic [PC_W-1:0] tgt_pc;
      assign seq_pc = pc + STEP;
      assign tgt_pc = seq_pc + disp;
      assign npc    = take ? tgt_pc : seq_pc;
   end else begin : g_single
      logic [PC_W-1:0] addend;
      assign addend = take ? disp : '0;
      assign npc    = pc + STEP + addend;
   end
endmodule

// File: rtl/brnch_next_pc.sv
module brnch_next_pc #(
   parameter int PC_W       = 16,
   parameter int OPC_W      = 5,
   parameter int OFS_W      = 8,
   parameter bit DUAL_ADDER = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [PC_W-1:0] cur_pc,
   input  logic [15:0]     insn,
   input  logic            flag_c,
   input  logic            flag_z,
   input  logic            flag_n,
   output logic [PC_W-1:0] next_pc,
   output logic            br_taken
);
   import brnch_pkg::*;

   localparam int INSN_W = OPC_W + FLAG_CNT + OFS_W;

   if (INSN_W != 16) begin : g_bad_fmt
      $error("field widths must total the 16-bit instruction");
   end
   if (PC_W < OFS_W + 2) begin : g_bad_pc
      $error("PC too narrow for the scaled offset");
   end

   logic                is_br;
   logic [FLAG_CNT-1:0] sel;
   logic [FLAG_CNT-1:0] flags;
   logic [OFS_W-1:0]    ofs;
   logic                take;
   logic [PC_W-1:0]     npc;

   always_comb begin
      flags       = '0;
      flags[FI_C] = flag_c;
      flags[FI_Z] = flag_z;
      flags[FI_N] = flag_n;
   end

   brnch_decode #(.OPC_W(OPC_W), .OFS_W(OFS_W), .INSN_W(INSN_W)) u_dec (
      .insn (insn[INSN_W-1:0]),
      .is_br(is_br),
      .sel  (sel),
      .ofs  (ofs)
   );

   brnch_cond #(.NF(FLAG_CNT)) u_cond (
      .is_br(is_br),
      .sel  (sel),
      .flags(flags),
      .take (take)
   );

   brnch_target #(.PC_W(PC_W), .OFS_W(OFS_W), .DUAL_ADDER(DUAL_ADDER)) u_tgt (
      .pc  (cur_pc),
      .ofs (ofs),
      .take(take),
      .npc (npc)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         next_pc  <= '0;
         br_taken <= 1'b0;
      end else begin
         next_pc  <= npc;
         br_taken <= take;
      end
   end
endmodule

// File: rtl/brnch_next_pc_chk.sv
module brnch_next_pc_chk #(
   parameter int PC_W = 16
) (
   input logic            clk,
   input logic            rst_n,
   input logic [PC_W-1:0] cur_pc,
   input logic [15:0]     insn,
   input logic            flag_c,
   input logic            flag_z,
   input logic            flag_n,
   input logic [PC_W-1:0] next_pc,
   input logic            br_taken
);
   logic [PC_W-1:0] disp;
   assign disp = PC_W'({{(PC_W-8){insn[7]}}, insn[7:0]}) << 1;

   logic hit_any;
   assign hit_any = (insn[10] & flag_c) | (insn[9] & flag_z) | (insn[8] & flag_n);

   // R1: reset clears outputs
   a_r1_reset_clear: assert property (@(posedge clk)
      !rst_n |=> (next_pc == '0 && !br_taken));

   // R3: non-branch opcode advances sequentially
   a_r3_non_branch: assert property (@(posedge clk) disable iff (!rst_n)
      insn[15:11] != 5'b0 |=> (!br_taken && next_pc == $past(cur_pc) + PC_W'(2)));

   // R5: empty select never branches
   a_r5_empty_mask: assert property (@(posedge clk) disable iff (!rst_n)
      insn[10:8] == 3'b0 |=> !br_taken);

   // R4: taken exactly when a selected flag is set on a branch
   a_r4_condition: assert property (@(posedge clk) disable iff (!rst_n)
      (insn[15:11] == 5'b0) |=> (br_taken == $past(hit_any)));

   // R6: taken target
   a_r6_target: assert property (@(posedge clk) disable iff (!rst_n)
      (insn[15:11] == 5'b0 && hit_any) |=>
         (next_pc == $past(cur_pc) + PC_W'(2) + $past(disp)));

   // R7: not-taken branch falls through
   a_r7_fall_through: assert property (@(posedge clk) disable iff (!rst_n)
      (insn[15:11] == 5'b0 && !hit_any) |=> (next_pc == $past(cur_pc) + PC_W'(2)));
endmodule

bind brnch_next_pc brnch_next_pc_chk #(.PC_W(PC_W)) u_chk (.*);

// File: tb/brnch_next_pc_bench.sv
module brnch_next_pc_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] cur_pc = '0;
   logic [15:0] insn = '0;
   logic        flag_c = 1'b0;
   logic        flag_z = 1'b0;
   logic        flag_n = 1'b0;
   logic [15:0] next_pc;
   logic        br_taken;

   int vectors = 0;
   int errors  = 0;
   bit have_exp = 0;
   logic [15:0] exp_pc;
   logic        exp_tk;
   string       exp_tag;
   bit          done = 0;

   always #2.5 clk = ~clk;

   brnch_next_pc u_brnch_next_pc (
      .clk(clk), .rst_n(rst_n), .cur_pc(cur_pc), .insn(insn),
      .flag_c(flag_c), .flag_z(flag_z), .flag_n(flag_n),
      .next_pc(next_pc), .br_taken(br_taken)
   );

   // Behavioural model built from the requirements
   task automatic model(input logic [15:0] pc, input logic [15:0] w,
                        input logic c, input logic z, input logic n,
                        output logic [15:0] npc, output logic tk);
      int off;
      bit br;
      br  = (w[15:11] == 5'd0);
      tk  = br && ((w[10] && c) || (w[9] && z) || (w[8] && n));
      off = w[7] ? int'(w[7:0]) - 256 : int'(w[7:0]);
      npc = 16'((int'(pc) + 2 + (tk ? 2 * off : 0)) & 32'hFFFF);
   endtask

   task automatic compare();
      vectors++;
      if (next_pc !== exp_pc || br_taken !== exp_tk) begin
         errors++;
         $display("FAIL %s: next_pc=%h taken=%b expected next_pc=%h taken=%b",
                  exp_tag, next_pc, br_taken, exp_pc, exp_tk);
      end
   endtask

   // Apply a vector at the negedge; result checked at the following negedge
   task automatic apply(input logic [15:0] pc, input logic [15:0] w,
                        input logic c, input logic z, input logic n,
                        input string tag);
      @(negedge clk);
      if (have_exp) compare();
      cur_pc = pc; insn = w; flag_c = c; flag_z = z; flag_n = n;
      model(pc, w, c, z, n, exp_pc, exp_tk);
      exp_tag  = tag;
      have_exp = 1;
   endtask

   initial begin
      logic [15:0] lfsr;
      // R1: outputs cleared during reset even with branch-worthy inputs
      cur_pc = 16'h1234; insn = 16'h0700; flag_c = 1; flag_z = 1; flag_n = 1;
      repeat (3) @(negedge clk);
      vectors++;
      if (next_pc !== 16'h0 || br_taken !== 1'b0) begin
         errors++;
         $display("FAIL R1: next_pc=%h taken=%b expected next_pc=0000 taken=0",
                  next_pc, br_taken);
      end
      rst_n = 1'b1;

      // R9: worked example
      apply(16'h200C, 16'h03E3, 0, 0, 1, "R9 nf");
      apply(16'h200C, 16'h03E3, 1, 0, 0, "R9 cf");
      // R4: each flag matched to its own select bit, one at a time
      apply(16'h1000, 16'h0405, 1, 0, 0, "R4 c");
      apply(16'h1000, 16'h0205, 0, 1, 0, "R4 z");
      apply(16'h1000, 16'h0105, 0, 0, 1, "R4 n");
      apply(16'h1000, 16'h0405, 0, 1, 1, "R4 c off");
      apply(16'h1000, 16'h0205, 1, 0, 1, "R4 z off");
      apply(16'h1000, 16'h0105, 1, 1, 0, "R4 n off");
      apply(16'h1000, 16'h0610, 0, 1, 0, "R4 ule");
      // R5: empty mask
      apply(16'h3000, 16'h0040, 1, 1, 1, "R5");
      // R3: other opcodes ignore mask and flags
      apply(16'h4000, 16'h0F7F, 1, 1, 1, "R3 op01");
      apply(16'h4000, 16'hFFFF, 1, 1, 1, "R3 op1f");
      // R6: extreme offsets
      apply(16'h5000, 16'h047F, 1, 0, 0, "R6 +127");
      apply(16'h5000, 16'h0480, 1, 0, 0, "R6 -128");
      apply(16'h5000, 16'h04FF, 1, 0, 0, "R6 -1");
      // R7: not taken
      apply(16'h6000, 16'h0780, 0, 0, 0, "R7");
      // R8: wrap both directions
      apply(16'hFFFE, 16'h0000, 0, 0, 0, "R8 seq wrap");
      apply(16'hFFF0, 16'h0410, 1, 0, 0, "R8 fwd wrap");
      apply(16'h0004, 16'h04F0, 1, 0, 0, "R8 back wrap");
      // R2: consecutive differing vectors, one-cycle pipeline
      lfsr = 16'hACE1;
      for (int i = 0; i < 300; i++) begin
         logic [15:0] w;
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         w = {lfsr[3] ? 5'd0 : lfsr[15:11], lfsr[10:0] ^ 11'(i * 37)};
         apply(lfsr ^ 16'(i * 977), w, lfsr[0], lfsr[5], lfsr[9], "R2 mix");
      end
      @(negedge clk);
      compare();
      done = 1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (5000) @(posedge clk);
            errors++;
            $display("FAIL watchdog: run hung, expected completion");
         end
      join_any
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end
endmodule